// File: doc/BRIEF.md
# Gray-Code Up/Down Counter

This block is a synchronous counter that keeps its state as a reflected Gray code word. It moves one step up or one step down on each clock where stepping is enabled. The next state comes from combinational logic. A prefix-XOR network first decodes the stored Gray word into binary. A prefix carry network then adds or removes one. The result is encoded back into Gray code and written to the register.

A terminal-count flag tells the surrounding logic that the next step in the currently chosen direction will wrap the count. In Gray code the wrap runs between the all-zero word and the word that has only its top bit set. Because the state is already in Gray code, a consumer in another clock domain can sample the count without a separate encoder.

Top module: `gray_updown_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the count becomes all zeros.
- R2: While `step_en` is low, the count keeps its value.
- R3: When `step_en` is high and `count_up` is 1, the binary value that the Gray count represents rises by one, modulo 2^WIDTH.
- R4: When `step_en` is high and `count_up` is 0, the binary value falls by one, modulo 2^WIDTH.
- R5: The count uses reflected Gray code. Bit i equals b[i] XOR b[i+1] of the binary value, and the top bit equals the top binary bit.
- R6: Every step, including the wrap in either direction, changes exactly one bit of `gray_q`.
- R7: `term_cnt` is high exactly when the next step in the selected direction would wrap. Counting up, that is binary all ones (Gray: only the top bit set). Counting down, that is binary zero (Gray: all zeros). The flag follows `count_up` combinationally and does not depend on `step_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Step enable |
| count_up | input | 1 | 1 = count up, 0 = count down |
| gray_q | output | WIDTH | Registered Gray-coded count |
| term_cnt | output | 1 | Next step in the selected direction wraps |

## Verification
Two functions can fall in the same cycle: the terminal-count indication and the wrap step that follows it. Either direction can also be reversed at the very cycle the counter sits on a boundary. The bench drives the counter to all ones in binary and to zero, then toggles `count_up` while the count is held. It checks that the flag follows the direction input at once. It then steps across the wrap and compares the result with a reference binary counter encoded into Gray code. The bench also checks that each step changes exactly one bit.

// File: rtl/gray_cnt_pkg.sv
package gray_cnt_pkg;
  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} dir_e;
endpackage

// File: rtl/gray_to_bin.sv
module gray_to_bin #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] gray_i,
  output logic [WIDTH-1:0] bin_o
);
  // suffix XOR from the MSB downward
  assign bin_o[WIDTH-1] = gray_i[WIDTH-1];
  for (genvar i = WIDTH - 2; i >= 0; i--) begin : g_px
    assign bin_o[i] = bin_o[i+1] ^ gray_i[i];
  end
endmodule

// File: rtl/bin_step.sv
module bin_step #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] bin_i,
  input  logic             up_i,
  output logic [WIDTH-1:0] bin_o,
  output logic             wrap_o
);
  // Up: flip when all lower bits are 1. Down: flip when all lower bits are 0.
  // Both cases use one prefix-AND over bits conditioned on the direction.
  logic [WIDTH-1:0] cond;
  logic [WIDTH:0]   pre;
  assign cond   = up_i ? bin_i : ~bin_i;
  assign pre[0] = 1'b1;
  for (genvar i = 0; i < WIDTH; i++) begin : g_pa
    assign pre[i+1]  = pre[i] & cond[i];
    assign bin_o[i]  = bin_i[i] ^ pre[i];
  end
  assign wrap_o = pre[WIDTH];
endmodule

// File: rtl/bin_to_gray.sv
module bin_to_gray #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] bin_i,
  output logic [WIDTH-1:0] gray_o
);
  assign gray_o = bin_i ^ (bin_i >> 1);
endmodule

// File: rtl/gray_updown_counter.sv
module gray_updown_counter
  import gray_cnt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic             count_up,
  output logic [WIDTH-1:0] gray_q,
  output logic             term_cnt
);
  localparam logic [WIDTH-1:0] TOP_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  dir_e             dir;
  logic [WIDTH-1:0] cur_bin, nxt_bin, nxt_gray;
  logic             wrap;

  assign dir = dir_e'(count_up);

  gray_to_bin #(.WIDTH(WIDTH)) u_g2b (.gray_i(gray_q), .bin_o(cur_bin));
  bin_step    #(.WIDTH(WIDTH)) u_stp (.bin_i(cur_bin), .up_i(dir == DIR_UP),
                                      .bin_o(nxt_bin), .wrap_o(wrap));
  bin_to_gray #(.WIDTH(WIDTH)) u_b2g (.bin_i(nxt_bin), .gray_o(nxt_gray));

  always_ff @(posedge clk) begin
    if (rst)          gray_q <= '0;
    else if (step_en) gray_q <= nxt_gray;
  end

  assign term_cnt = wrap;

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> gray_q == '0) else $error("R1"); // R1
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(gray_q)) else $error("R2"); // R2
  AST_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    step_en |=> $countones(gray_q ^ $past(gray_q)) == 1) else $error("R6"); // R6
  AST_TC_UP: assert property (@(posedge clk) disable iff (rst)
    (count_up && gray_q == TOP_ONLY) |-> term_cnt) else $error("R7"); // R7
  AST_TC_DN: assert property (@(posedge clk) disable iff (rst)
    (!count_up && gray_q == '0) |-> term_cnt) else $error("R7"); // R7
  AST_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
    (step_en && count_up && term_cnt) |=> gray_q == '0) else $error("R3"); // R3
  AST_WRAP_DN: assert property (@(posedge clk) disable iff (rst)
    (step_en && !count_up && term_cnt) |=> gray_q == TOP_ONLY) else $error("R4"); // R4
endmodule

// File: tb/tb_gray_updown_counter.sv
module tb_gray_updown_counter;
  localparam int W = 4;
  localparam int M = 1 << W;

  logic clk = 0, rst = 1, step_en = 0, count_up = 1;
  logic [W-1:0] gray_q;
  logic term_cnt;
  int checks = 0, errors = 0;
  int ref_b = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gray_updown_counter #(.WIDTH(W)) dut (.clk(clk), .rst(rst), .step_en(step_en),
    .count_up(count_up), .gray_q(gray_q), .term_cnt(term_cnt));

  function automatic logic [W-1:0] enc(int b);
    logic [W-1:0] v = b[W-1:0];
    return v ^ (v >> 1);
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(logic en, logic up);
    step_en = en; count_up = up;
    @(posedge clk); #1;
  endtask

  task automatic check_tc(string req);
    logic e = count_up ? (ref_b == M-1) : (ref_b == 0);
    chk(req, {{(W-1){1'b0}}, term_cnt}, {{(W-1){1'b0}}, e});
  endtask

  task automatic t_reset();
    rst = 1; step(0, 1); rst = 0; ref_b = 0;
    chk("R1", gray_q, '0);
  endtask

  task automatic t_up_run(int n);
    for (int i = 0; i < n; i++) begin
      logic [W-1:0] prev = gray_q;
      step(1, 1);
      ref_b = (ref_b + 1) % M;
      chk("R3/R5", gray_q, enc(ref_b));
      chk("R6", W'($countones(gray_q ^ prev)), W'(1));
      check_tc("R7");
    end
  endtask

  task automatic t_down_run(int n);
    for (int i = 0; i < n; i++) begin
      logic [W-1:0] prev = gray_q;
      step(1, 0);
      ref_b = (ref_b + M - 1) % M;
      chk("R4/R5", gray_q, enc(ref_b));
      chk("R6", W'($countones(gray_q ^ prev)), W'(1));
      check_tc("R7");
    end
  endtask

  task automatic t_hold();
    logic [W-1:0] s = gray_q;
    step(0, 1); step(0, 0); step(0, 1);
    chk("R2", gray_q, s);
  endtask

  task automatic t_tc_dir();
    // flag follows direction without stepping
    step(0, 1); check_tc("R7");
    step(0, 0); check_tc("R7");
  endtask

  task automatic t_reset_mid();
    step(1, 1); ref_b = (ref_b + 1) % M;
    rst = 1; step(1, 1); rst = 0; ref_b = 0;
    chk("R1", gray_q, '0);
  endtask

  initial begin
    t_reset();
    check_tc("R7");
    t_tc_dir();
    t_down_run(3);          // wraps down through zero
    t_up_run(2 * M);        // full cycles incl. up-wrap
    t_hold();
    t_up_run(M - 1 - ref_b);// sit at all-ones
    t_tc_dir();
    t_up_run(1);            // R3 wrap
    t_tc_dir();
    t_down_run(1);          // R4 wrap
    t_down_run(M + 2);
    t_reset_mid();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done"); end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule